// File: doc/BRIEF.md
# Multi-Domain Reset Sequencer with Last-Cause Capture

This block collects reset requests from eight sources and drives five separate domain resets: CPU and bus, an always-on group (real-time clock, slow oscillator control and supply registers that survive backup), flash controller with main oscillator, debug, and every other module. Each source drives only its own set of domains. A brown-out or a watchdog event therefore restarts the core and leaves the always-on group and the flash clocking running. A wake from backup by the real-time clock also leaves the always-on group untouched.

Any active source sets its domain resets at once, without waiting for a clock edge. Each domain has its own release sequencer, a small state machine with the states HOLD, COUNT and RUN. While the domain's request is present or still passing through the two-stage synchroniser, the machine stays in HOLD. When the synchronised request is low it goes HOLD→COUNT. After the stretch count it goes COUNT→RUN. A new request forces any state back to HOLD. The domain reset is high in every state except RUN.

A one-hot cause register records the most recent reset source. When several sources are active together, a fixed priority picks the recorded source. Boot software reads the register through a one-cycle read port. The block has no enable and runs all the time.

Top module: `rst_domain_ctrl`

## Requirements
- R1: Power-on (`por_req` high) sets all five domain resets and presets the cause register to 8'h01.
- R2: Core power-on (`core_por_req` high) sets all five domain resets; recorded cause 8'h02.
- R3: Brown-out (`bod_req` high) or a low external pin (`ext_rst_n` = 0) sets the CPU, debug and other-module resets only; the always-on and flash resets stay low. Causes 8'h04 and 8'h08.
- R4: Watchdog, CPU lockup and CPU system request set only the CPU and other-module resets. Recorded causes: watchdog 8'h10, system request 8'h20, lockup 8'h40.
- R5: Backup wake by the real-time clock sets the CPU, flash, debug and other-module resets and leaves the always-on reset low; cause 8'h80.
- R6: A domain reset rises within the same clock cycle as its source, before the next rising edge.
- R7: A domain reset stays high through the 18th rising edge after its last source drops and falls at the 19th (two synchroniser stages, one hand-off edge, 16 stretch cycles). A new source during the stretch restarts the count.
- R8: The cause register is one-hot (bit 0 POR, 1 core POR, 2 brown-out, 3 external, 4 watchdog, 5 system request, 6 lockup, 7 backup wake). It keeps the latest cause and does not change while no source is active.
- R9: When sources are active together, the recorded cause follows this priority from high to low: POR, core POR, brown-out, external, watchdog, lockup, system request, backup wake.
- R10: When `cause_rd` is high at a rising edge, `cause_rdata` shows the cause register after that edge. Otherwise `cause_rdata` is zero after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running controller clock |
| por_req | input | 1 | Power-on request, active high, asynchronous |
| core_por_req | input | 1 | Core-supply power-on request, active high |
| bod_req | input | 1 | Brown-out request, active high |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_req | input | 1 | Watchdog expiry request, active high |
| lockup_req | input | 1 | CPU lockup request, active high |
| sysreq_req | input | 1 | CPU software reset request, active high |
| bkup_wake_req | input | 1 | Backup/hibernate exit by RTC wake, active high |
| cpu_rst | output | 1 | CPU and bus domain reset, active high |
| aon_rst | output | 1 | Always-on group reset, active high |
| flash_rst | output | 1 | Flash controller and main oscillator reset |
| dbg_rst | output | 1 | Debug logic reset |
| misc_rst | output | 1 | Reset of all other modules |
| cause_rd | input | 1 | Cause read strobe |
| cause_rdata | output | 8 | Cause read data, one cycle after the strobe |

## Verification
The bench checks that the always-on and flash domains stay low for user, brown-out and watchdog events. A matrix row in the wrong place would clear the real-time clock or stop the main oscillator on an ordinary watchdog reset. It checks the release edge exactly at the 18th and 19th edges, which catches a stretch that is off by one or a synchroniser stage that was dropped. It also checks that a second source arriving during the stretch restarts the count; without the restart the core would come out of reset while a request is still pending. Simultaneous sources check the priority, including lockup over system request even though their bit positions run the other way, so a plain bit-order encoder would report the wrong cause.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int NSRC = 8;
    localparam int NDOM = 5;

    // source bit positions in the cause register
    localparam int SRC_POR    = 0;
    localparam int SRC_CPOR   = 1;
    localparam int SRC_BOD    = 2;
    localparam int SRC_EXT    = 3;
    localparam int SRC_WDT    = 4;
    localparam int SRC_SYSREQ = 5;
    localparam int SRC_LOCKUP = 6;
    localparam int SRC_BKUP   = 7;

    // domain indices
    localparam int DOM_CPU   = 0;
    localparam int DOM_AON   = 1;
    localparam int DOM_FLASH = 2;
    localparam int DOM_DBG   = 3;
    localparam int DOM_MISC  = 4;

    // which sources drive each domain
    localparam logic [NSRC-1:0] DOM_MASK [NDOM] = '{
        8'hFF,   // CPU/bus: every source
        8'h03,   // always-on: power-on types only
        8'h83,   // flash/osc: power-on types and backup wake
        8'h8F,   // debug: power-on, brown-out, pin, backup wake
        8'hFF    // other modules: every source
    };

    // cause priority, highest first
    localparam int PRIO_ORDER [NSRC] = '{
        SRC_POR, SRC_CPOR, SRC_BOD, SRC_EXT,
        SRC_WDT, SRC_LOCKUP, SRC_SYSREQ, SRC_BKUP
    };

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2
    } stretch_st_e;

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // asynchronous set captures even a short request; release walks the chain
        always_ff @(posedge clk or posedge async_in[g]) begin
            if (async_in[g]) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], 1'b0};
            end
        end

        assign sync_out[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic req,
    output logic rst_out
);

    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic           req_s;
    stretch_st_e    state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    rstc_sync #(
        .WIDTH  (1),
        .STAGES (2)
    ) u_req_sync (
        .clk      (clk),
        .async_in (req),
        .sync_out (req_s)
    );

    // state register: a request forces HOLD at once
    always_ff @(posedge clk or posedge req) begin
        if (req) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_HOLD: begin
                if (!req_s) begin
                    state_nx = ST_COUNT;
                    cnt_nx   = '0;
                end
            end
            ST_COUNT: begin
                if (req_s) begin
                    state_nx = ST_HOLD;
                end else if (cnt == LAST) begin
                    state_nx = ST_RUN;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (req_s) begin
                    state_nx = ST_HOLD;
                end
            end
            default: state_nx = ST_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        rst_out = (state != ST_RUN);
    end

endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
    import rstc_pkg::*;
(
    input  logic            clk,
    input  logic            por_async,
    input  logic [NSRC-1:0] src_sync,
    input  logic            rd,
    output logic [NSRC-1:0] cause_q,
    output logic [NSRC-1:0] rdata
);

    logic [NSRC-1:0] pick;

    // walk from lowest to highest priority so the highest wins
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (src_sync[PRIO_ORDER[i]]) begin
                pick = '0;
                pick[PRIO_ORDER[i]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge por_async) begin
        if (por_async) begin
            cause_q <= NSRC'(1) << SRC_POR;
        end else if (|src_sync) begin
            cause_q <= pick;
        end
    end

    always_ff @(posedge clk or posedge por_async) begin
        if (por_async) begin
            rdata <= '0;
        end else begin
            rdata <= rd ? cause_q : '0;
        end
    end

endmodule

// File: rtl/rst_domain_ctrl.sv
module rst_domain_ctrl
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       core_por_req,
    input  logic       bod_req,
    input  logic       ext_rst_n,
    input  logic       wdt_req,
    input  logic       lockup_req,
    input  logic       sysreq_req,
    input  logic       bkup_wake_req,
    output logic       cpu_rst,
    output logic       aon_rst,
    output logic       flash_rst,
    output logic       dbg_rst,
    output logic       misc_rst,
    input  logic       cause_rd,
    output logic [7:0] cause_rdata
);

    logic [NSRC-1:0] src_raw;
    logic [NSRC-1:0] src_sync;
    logic [NDOM-1:0] dom_req;
    logic [NDOM-1:0] dom_rst;
    logic [NSRC-1:0] cause_q;

    always_comb begin
        src_raw             = '0;
        src_raw[SRC_POR]    = por_req;
        src_raw[SRC_CPOR]   = core_por_req;
        src_raw[SRC_BOD]    = bod_req;
        src_raw[SRC_EXT]    = ~ext_rst_n;
        src_raw[SRC_WDT]    = wdt_req;
        src_raw[SRC_SYSREQ] = sysreq_req;
        src_raw[SRC_LOCKUP] = lockup_req;
        src_raw[SRC_BKUP]   = bkup_wake_req;
    end

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        assign dom_req[d] = |(src_raw & DOM_MASK[d]);

        rstc_stretch #(
            .HOLD_CYC (HOLD_CYC)
        ) u_stretch (
            .clk     (clk),
            .req     (dom_req[d]),
            .rst_out (dom_rst[d])
        );
    end

    rstc_sync #(
        .WIDTH  (NSRC),
        .STAGES (2)
    ) u_src_sync (
        .clk      (clk),
        .async_in (src_raw),
        .sync_out (src_sync)
    );

    rstc_cause u_cause (
        .clk       (clk),
        .por_async (por_req),
        .src_sync  (src_sync),
        .rd        (cause_rd),
        .cause_q   (cause_q),
        .rdata     (cause_rdata)
    );

    assign cpu_rst   = dom_rst[DOM_CPU];
    assign aon_rst   = dom_rst[DOM_AON];
    assign flash_rst = dom_rst[DOM_FLASH];
    assign dbg_rst   = dom_rst[DOM_DBG];
    assign misc_rst  = dom_rst[DOM_MISC];

endmodule

// File: rtl/rstc_chk.sv
module rstc_chk (
    input logic       clk,
    input logic       por_req,
    input logic       core_por_req,
    input logic       bod_req,
    input logic       ext_rst_n,
    input logic       wdt_req,
    input logic       lockup_req,
    input logic       sysreq_req,
    input logic       bkup_wake_req,
    input logic       cpu_rst,
    input logic       aon_rst,
    input logic       flash_rst,
    input logic       dbg_rst,
    input logic       misc_rst,
    input logic [7:0] cause_q,
    input logic       cause_rd,
    input logic [7:0] cause_rdata
);

    logic src_none;
    assign src_none = !(por_req || core_por_req || bod_req || !ext_rst_n ||
                        wdt_req || lockup_req || sysreq_req || bkup_wake_req);

    AST_AON_ONLY_CPOR: assert property (@(posedge clk) disable iff (por_req)
        $rose(aon_rst) |-> core_por_req);                               // R4

    AST_FLASH_SRC: assert property (@(posedge clk) disable iff (por_req)
        $rose(flash_rst) |-> (core_por_req || bkup_wake_req));          // R5

    AST_DBG_SRC: assert property (@(posedge clk) disable iff (por_req)
        $rose(dbg_rst) |-> (core_por_req || bod_req || !ext_rst_n ||
                            bkup_wake_req));                            // R3

    AST_CPU_MISC_PAIR: assert property (@(posedge clk) disable iff (por_req)
        cpu_rst == misc_rst);                                           // R4

    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (por_req)
        $countones(cause_q) == 1);                                      // R8

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (por_req)
        $fell(misc_rst) |-> ($past(src_none) && $past(src_none, 2)));   // R7

    AST_READ_DATA: assert property (@(posedge clk) disable iff (por_req)
        cause_rd |=> cause_rdata == $past(cause_q));                    // R10

    AST_READ_IDLE: assert property (@(posedge clk) disable iff (por_req)
        !cause_rd |=> cause_rdata == 8'h00);                            // R10

endmodule

bind rst_domain_ctrl rstc_chk u_chk (
    .clk           (clk),
    .por_req       (por_req),
    .core_por_req  (core_por_req),
    .bod_req       (bod_req),
    .ext_rst_n     (ext_rst_n),
    .wdt_req       (wdt_req),
    .lockup_req    (lockup_req),
    .sysreq_req    (sysreq_req),
    .bkup_wake_req (bkup_wake_req),
    .cpu_rst       (cpu_rst),
    .aon_rst       (aon_rst),
    .flash_rst     (flash_rst),
    .dbg_rst       (dbg_rst),
    .misc_rst      (misc_rst),
    .cause_q       (cause_q),
    .cause_rd      (cause_rd),
    .cause_rdata   (cause_rdata)
);

// File: tb/rst_domain_ctrl_tb.sv
`timescale 1ns/1ps
module rst_domain_ctrl_tb;

    logic       clk = 1'b0;
    logic       por_req, core_por_req, bod_req, ext_rst_n;
    logic       wdt_req, lockup_req, sysreq_req, bkup_wake_req;
    logic       cpu_rst, aon_rst, flash_rst, dbg_rst, misc_rst;
    logic       cause_rd;
    logic [7:0] cause_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    rst_domain_ctrl u_dut (
        .clk           (clk),
        .por_req       (por_req),
        .core_por_req  (core_por_req),
        .bod_req       (bod_req),
        .ext_rst_n     (ext_rst_n),
        .wdt_req       (wdt_req),
        .lockup_req    (lockup_req),
        .sysreq_req    (sysreq_req),
        .bkup_wake_req (bkup_wake_req),
        .cpu_rst       (cpu_rst),
        .aon_rst       (aon_rst),
        .flash_rst     (flash_rst),
        .dbg_rst       (dbg_rst),
        .misc_rst      (misc_rst),
        .cause_rd      (cause_rd),
        .cause_rdata   (cause_rdata)
    );

    // {sources[7:0], domains {misc,dbg,flash,aon,cpu}, cause[7:0]}
    localparam logic [20:0] VEC [12] = '{
        {8'h01, 5'h1F, 8'h01},
        {8'h02, 5'h1F, 8'h02},
        {8'h04, 5'h19, 8'h04},
        {8'h08, 5'h19, 8'h08},
        {8'h10, 5'h11, 8'h10},
        {8'h20, 5'h11, 8'h20},
        {8'h40, 5'h11, 8'h40},
        {8'h80, 5'h1D, 8'h80},
        {8'h60, 5'h11, 8'h40},
        {8'h90, 5'h1D, 8'h10},
        {8'h18, 5'h19, 8'h08},
        {8'h06, 5'h1F, 8'h02}
    };

    function automatic logic [4:0] doms();
        return {misc_rst, dbg_rst, flash_rst, aon_rst, cpu_rst};
    endfunction

    function automatic string tag_of(input logic [7:0] s);
        if ($countones(s) > 1) return "R9";
        case (s)
            8'h01: return "R1";
            8'h02: return "R2";
            8'h04, 8'h08: return "R3";
            8'h10, 8'h20, 8'h40: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] s);
        por_req       = s[0];
        core_por_req  = s[1];
        bod_req       = s[2];
        ext_rst_n     = ~s[3];
        wdt_req       = s[4];
        sysreq_req    = s[5];
        lockup_req    = s[6];
        bkup_wake_req = s[7];
    endtask

    task automatic read_cause(input string tag, input logic [7:0] exp);
        @(negedge clk) cause_rd = 1'b1;
        @(negedge clk) cause_rd = 1'b0;
        check({tag, " R10 read"}, 32'(cause_rdata), 32'(exp));
        @(negedge clk);
        check("R10 idle zero", 32'(cause_rdata), 32'h0);
    endtask

    // pulse a source pattern, check immediate assertion, exact release, cause
    task automatic run_vec(input logic [7:0] s, input logic [4:0] ed, input logic [7:0] ec);
        string t;
        t = tag_of(s);
        @(negedge clk) drive(s);
        #0.5;
        check({t, " R6 domains on assert"}, 32'(doms()), 32'(ed));
        repeat (4) @(negedge clk);
        drive(8'h00);
        repeat (18) @(posedge clk);
        #1;
        check({t, " R7 held at edge 18"}, 32'(doms()), 32'(ed));
        @(posedge clk);
        #1;
        check({t, " R7 released at edge 19"}, 32'(doms()), 32'h0);
        read_cause({t, " R8 cause"}, ec);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cause_rd = 1'b0;
        drive(8'h01);
        #1;
        check("R1 all domains in power-on", 32'(doms()), 32'h1F);
        repeat (5) @(negedge clk);
        drive(8'h00);
        repeat (19) @(posedge clk);
        #1;
        check("R1 released after power-on", 32'(doms()), 32'h0);
        @(negedge clk);
        check("R10 no read gives zero", 32'(cause_rdata), 32'h0);
        read_cause("R1 power-on cause", 8'h01);

        for (int i = 0; i < 12; i++) begin
            run_vec(VEC[i][20:13], VEC[i][12:8], VEC[i][7:0]);
        end

        // no source for a while: cause kept (last vector core POR)
        repeat (30) @(negedge clk);
        read_cause("R8 cause kept while quiet", 8'h02);

        // restart of the stretch by a second source
        @(negedge clk) drive(8'h10);
        repeat (3) @(negedge clk);
        drive(8'h00);
        repeat (10) @(posedge clk);
        @(negedge clk) drive(8'h08);
        #0.5;
        check("R7 debug joins during stretch", 32'(doms()), 32'h19);
        repeat (3) @(negedge clk);
        drive(8'h00);
        repeat (18) @(posedge clk);
        #1;
        check("R7 restarted hold at edge 18", 32'(doms()), 32'h19);
        @(posedge clk);
        #1;
        check("R7 restarted release", 32'(doms()), 32'h0);
        read_cause("R8 latest cause external", 8'h08);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule